// File: doc/BRIEF.md
# AXI Burst to Fixed Memory Burst Splitter

This block takes one AXI4 address-channel request (start address, beat count minus one, beat size and burst type) and turns it into a run of memory commands. Each command covers one fixed memory burst of `MEM_BL` bus words, where `MEM_BL` is 4 or 8. A chunk is therefore `DATA_BYTES*MEM_BL` bytes. Every command carries the chunk-aligned memory address and a record for the data path. The record gives the number of AXI beats the chunk carries and the byte offset of the first of those beats inside the chunk. The data-channel logic uses this record to pace beats against the memory user interface.

One instance serves the read address channel and another serves the write address channel, so reads and writes are split at the same time and independently of each other. On a write instance built with ECC, each command is tagged as a read-modify-write whenever the chunk is not fully covered by the AXI burst. A byte not covered by the burst has its mask bit active, so such a chunk needs a merge with the stored data. A fully covered chunk is tagged as a plain write. Requests are assumed to use a beat size no wider than the data bus, and WRAP requests a legal length of 2, 4, 8 or 16 beats.

Top module: `axi_burst_chunker`

## Requirements
- R1: `s_ready` is high exactly when no request is being split. A request is taken on a clock edge where `s_valid` and `s_ready` are both high. Its first command shows on `m_valid` in the next cycle, and `s_ready` stays low until the last command has been accepted.
- R2: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_addr`, `m_beats`, `m_offset`, `m_last` and `m_rmw` keep their values.
- R3: Every `m_addr` is a multiple of the chunk size `DATA_BYTES*MEM_BL` bytes (64 by default, 32 when `MEM_BL` is 4 with 8-byte words).
- R4: For an INCR request, the start address is first aligned down to the beat size. Commands then follow in ascending chunk order, and each one covers every beat whose address falls in its chunk. `m_beats` is that beat count. `m_offset` is the byte offset of the chunk's first beat, which is non-zero only on the first command.
- R5: For a WRAP request whose region, `(len+1)<<size` bytes, is no larger than a chunk, exactly one command is issued. It has `m_beats` = len+1 and `m_offset` = the start address's offset within its chunk.
- R6: For a WRAP request whose region is larger than a chunk, region/chunk commands are issued. The first is the chunk holding the start address, and the rest are the following chunks, continuing modulo the aligned region. Each command has `m_beats` = chunk bytes >> size. `m_offset` is the start offset on the first command and 0 on the others.
- R7: `m_last` is high on the final command of each request and low on all others. In the cycle after that command is accepted, `s_ready` is high and `m_valid` is low.
- R8: On a write instance with ECC (`IS_WRITE`=1, `ECC_EN`=1), `m_rmw` is 1 when `m_beats<<size` is smaller than the chunk size, and 0 when the chunk is fully covered. On any other instance `m_rmw` is always 0.
- R9: Burst code 2'b10 selects WRAP. Every other code (2'b00, 2'b01, 2'b11) is split as INCR.
- R10: After reset, `s_ready` is 1 and `m_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | AXI address request valid |
| s_ready | output | 1 | Request accepted when high together with `s_valid` |
| s_addr | input | ADDR_W | AXI start byte address |
| s_len | input | LEN_W | AXI beat count minus one |
| s_size | input | 3 | log2 of bytes per AXI beat |
| s_burst | input | 2 | Burst type, 2'b10 = WRAP, other codes = INCR |
| m_valid | output | 1 | Memory command valid |
| m_ready | input | 1 | Memory command accepted |
| m_addr | output | ADDR_W | Chunk-aligned memory address |
| m_beats | output | $clog2(DATA_BYTES*MEM_BL)+1 | AXI beats carried by this chunk |
| m_offset | output | $clog2(DATA_BYTES*MEM_BL) | Byte offset of the chunk's first beat |
| m_last | output | 1 | Final command of the request |
| m_rmw | output | 1 | Command needs read-modify-write |

## Verification
The splitter is driven with INCR requests that start on a chunk boundary, which give only full chunks. It is also driven with INCR requests that start mid-chunk, which produce a partial head chunk and a partial tail chunk and so bring out the offset and the merge tag. A narrow-size INCR request checks that beats are counted in AXI units rather than bus words. Two WRAP requests are used: one whose region fits inside a chunk, and one whose region spans two chunks and starts in the upper one, so the wrap back to the region base becomes visible. A short request with code 2'b00 is chosen so that its INCR result differs from what WRAP would give. The unaligned request is sent with back-pressure so that holding a command can be observed. A second instance with a four-word burst and no merge tagging runs alongside and gives a different chunk count.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

    localparam logic [1:0] BURST_CODE_WRAP = 2'b10;

    function automatic logic is_wrap_code(input logic [1:0] code);
        return code == BURST_CODE_WRAP;
    endfunction

endpackage

// File: rtl/bsplit_req_decode.sv
module bsplit_req_decode #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 8,
    parameter int CHUNK_BYTES = 64,
    localparam int REM_W      = LEN_W + 1
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [2:0]        req_size,
    input  logic [1:0]        req_burst,
    output logic [ADDR_W-1:0] start_addr,
    output logic [REM_W-1:0]  beat_total,
    output logic              wrap_en,
    output logic              wrap_small,
    output logic [ADDR_W-1:0] wrap_mask
);
    import bsplit_pkg::*;

    logic [ADDR_W-1:0] size_mask;
    logic [ADDR_W-1:0] region_bytes;

    always_comb begin
        size_mask    = (ADDR_W'(1) << req_size) - ADDR_W'(1);
        start_addr   = req_addr & ~size_mask;
        beat_total   = REM_W'(req_len) + REM_W'(1);
        region_bytes = ADDR_W'(beat_total) << req_size;
        wrap_en      = is_wrap_code(req_burst);
        wrap_small   = region_bytes <= ADDR_W'(CHUNK_BYTES);
        wrap_mask    = region_bytes - ADDR_W'(1);
    end

endmodule

// File: rtl/bsplit_chunk_calc.sv
module bsplit_chunk_calc #(
    parameter int ADDR_W      = 32,
    parameter int REM_W       = 9,
    parameter int CHUNK_BYTES = 64,
    localparam int OFF_W      = $clog2(CHUNK_BYTES),
    localparam int BEATS_W    = OFF_W + 1
) (
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [REM_W-1:0]   remain,
    input  logic [2:0]         size,
    input  logic               wrap_en,
    input  logic               wrap_small,
    input  logic [ADDR_W-1:0]  wrap_mask,
    output logic [ADDR_W-1:0]  chunk_addr,
    output logic [OFF_W-1:0]   offset,
    output logic [BEATS_W-1:0] beats,
    output logic [REM_W-1:0]   take,
    output logic [ADDR_W-1:0]  next_addr,
    output logic               last
);
    logic [BEATS_W-1:0] span_bytes;
    logic [BEATS_W-1:0] room_beats;
    logic [BEATS_W-1:0] full_beats;
    logic [REM_W-1:0]   cap;
    logic [ADDR_W-1:0]  step_addr;

    always_comb begin
        chunk_addr = {cur_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        offset     = cur_addr[OFF_W-1:0];
        span_bytes = BEATS_W'(CHUNK_BYTES) - {1'b0, offset};
        room_beats = span_bytes >> size;
        full_beats = BEATS_W'(CHUNK_BYTES) >> size;

        if (wrap_en && wrap_small) begin
            cap = remain;
        end else if (wrap_en) begin
            cap = REM_W'(full_beats);
        end else begin
            cap = REM_W'(room_beats);
        end

        take  = (remain < cap) ? remain : cap;
        beats = BEATS_W'(take);
        last  = (remain == take);

        step_addr = chunk_addr + ADDR_W'(CHUNK_BYTES);
        if (wrap_en) begin
            next_addr = (chunk_addr & ~wrap_mask) | (step_addr & wrap_mask);
        end else begin
            next_addr = step_addr;
        end
    end

endmodule

// File: rtl/axi_burst_chunker.sv
module axi_burst_chunker #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 8,
    parameter int DATA_BYTES = 8,
    parameter int MEM_BL     = 8,
    parameter bit IS_WRITE   = 1'b1,
    parameter bit ECC_EN     = 1'b1,
    localparam int CHUNK_BYTES = DATA_BYTES * MEM_BL,
    localparam int OFF_W       = $clog2(CHUNK_BYTES),
    localparam int BEATS_W     = OFF_W + 1,
    localparam int REM_W       = LEN_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [ADDR_W-1:0]  s_addr,
    input  logic [LEN_W-1:0]   s_len,
    input  logic [2:0]         s_size,
    input  logic [1:0]         s_burst,
    output logic               m_valid,
    input  logic               m_ready,
    output logic [ADDR_W-1:0]  m_addr,
    output logic [BEATS_W-1:0] m_beats,
    output logic [OFF_W-1:0]   m_offset,
    output logic               m_last,
    output logic               m_rmw
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] cur;
        logic [REM_W-1:0]  remain;
        logic [2:0]        size;
        logic              wrap;
        logic              wrap_small;
        logic [ADDR_W-1:0] mask;
    } split_st_t;

    split_st_t st_d, st_q;

    logic [ADDR_W-1:0] dec_start;
    logic [REM_W-1:0]  dec_total;
    logic              dec_wrap;
    logic              dec_small;
    logic [ADDR_W-1:0] dec_mask;

    logic [REM_W-1:0]  cur_take;
    logic [ADDR_W-1:0] cur_next;

    bsplit_req_decode #(
        .ADDR_W      (ADDR_W),
        .LEN_W       (LEN_W),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_decode (
        .req_addr   (s_addr),
        .req_len    (s_len),
        .req_size   (s_size),
        .req_burst  (s_burst),
        .start_addr (dec_start),
        .beat_total (dec_total),
        .wrap_en    (dec_wrap),
        .wrap_small (dec_small),
        .wrap_mask  (dec_mask)
    );

    bsplit_chunk_calc #(
        .ADDR_W      (ADDR_W),
        .REM_W       (REM_W),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_calc (
        .cur_addr   (st_q.cur),
        .remain     (st_q.remain),
        .size       (st_q.size),
        .wrap_en    (st_q.wrap),
        .wrap_small (st_q.wrap_small),
        .wrap_mask  (st_q.mask),
        .chunk_addr (m_addr),
        .offset     (m_offset),
        .beats      (m_beats),
        .take       (cur_take),
        .next_addr  (cur_next),
        .last       (m_last)
    );

    assign s_ready = !st_q.busy;
    assign m_valid = st_q.busy;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (s_valid) begin
                st_d.busy       = 1'b1;
                st_d.cur        = dec_start;
                st_d.remain     = dec_total;
                st_d.size       = s_size;
                st_d.wrap       = dec_wrap;
                st_d.wrap_small = dec_small;
                st_d.mask       = dec_mask;
            end
        end else if (m_ready) begin
            if (m_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cur    = cur_next;
                st_d.remain = st_q.remain - cur_take;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (IS_WRITE && ECC_EN) begin : g_merge_tag
            localparam int COV_W = BEATS_W + 8;
            logic [COV_W-1:0] covered_bytes;
            assign covered_bytes = COV_W'(m_beats) << st_q.size;
            assign m_rmw = covered_bytes != COV_W'(CHUNK_BYTES);
        end else begin : g_no_merge
            assign m_rmw = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/axi_burst_chunker_chk.sv
module axi_burst_chunker_chk #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 6,
    parameter int BEATS_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_valid,
    input logic               s_ready,
    input logic               m_valid,
    input logic               m_ready,
    input logic [ADDR_W-1:0]  m_addr,
    input logic [BEATS_W-1:0] m_beats,
    input logic [OFF_W-1:0]   m_offset,
    input logic               m_last,
    input logic               m_rmw
);
    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !s_ready); // R1

    AST_ACCEPT_STARTS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> m_valid); // R1

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_beats)
            && $stable(m_offset) && $stable(m_last) && $stable(m_rmw))); // R2

    AST_BEATS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_beats != '0)); // R4

    AST_LATER_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !m_last) |=> (m_offset == '0)); // R6

    AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> (s_ready && !m_valid)); // R7

endmodule

bind axi_burst_chunker axi_burst_chunker_chk #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .BEATS_W (BEATS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_addr   (m_addr),
    .m_beats  (m_beats),
    .m_offset (m_offset),
    .m_last   (m_last),
    .m_rmw    (m_rmw)
);

// File: tb/axi_burst_chunker_bench.sv
module axi_burst_chunker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DB         = 8;
    localparam int CHUNK      = DB * 8;
    localparam int CHUNK_RD   = DB * 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        s_valid = 1'b0;
    logic [31:0] s_addr = '0;
    logic [7:0]  s_len = '0;
    logic [2:0]  s_size = '0;
    logic [1:0]  s_burst = '0;
    logic        m_ready = 1'b0;

    logic        s_ready, m_valid, m_last, m_rmw;
    logic [31:0] m_addr;
    logic [6:0]  m_beats;
    logic [5:0]  m_offset;

    logic        rd_s_ready, rd_m_valid, rd_m_last, rd_m_rmw;
    logic [31:0] rd_m_addr;
    logic [5:0]  rd_m_beats;
    logic [4:0]  rd_m_offset;

    axi_burst_chunker #(.DATA_BYTES(DB), .MEM_BL(8), .IS_WRITE(1'b1), .ECC_EN(1'b1)) u_axi_burst_chunker (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_addr(s_addr), .s_len(s_len), .s_size(s_size), .s_burst(s_burst),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_beats(m_beats),
        .m_offset(m_offset), .m_last(m_last), .m_rmw(m_rmw)
    );

    axi_burst_chunker #(.DATA_BYTES(DB), .MEM_BL(4), .IS_WRITE(1'b0), .ECC_EN(1'b1)) u_axi_burst_chunker_rd (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(rd_s_ready),
        .s_addr(s_addr), .s_len(s_len), .s_size(s_size), .s_burst(s_burst),
        .m_valid(rd_m_valid), .m_ready(1'b1), .m_addr(rd_m_addr), .m_beats(rd_m_beats),
        .m_offset(rd_m_offset), .m_last(rd_m_last), .m_rmw(rd_m_rmw)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int rd_cnt = 0, rd_rmw = 0, rd_misalign = 0;

    always @(negedge clk) begin
        if (rst_n && rd_m_valid) begin
            rd_cnt++;
            if (rd_m_rmw) rd_rmw++;
            if (rd_m_addr[4:0] != 5'd0) rd_misalign++;
        end
    end

    logic [31:0] exp_addr  [0:63];
    int          exp_beats [0:63];
    int          exp_off   [0:63];
    int          n_exp;

    task automatic check_val(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic build_exp(input logic [31:0] addr, input int len, input int size, input logic [1:0] burst);
        int bytes;
        int region;
        logic [31:0] a, c, base;
        bytes = 1 << size;
        a = addr & ~(32'(bytes) - 32'd1);
        n_exp = 0;
        if (burst != 2'b10) begin
            for (int i = 0; i <= len; i++) begin
                c = a & ~32'(CHUNK - 1);
                if (n_exp == 0 || c != exp_addr[n_exp-1]) begin
                    exp_addr[n_exp]  = c;
                    exp_off[n_exp]   = int'(a & 32'(CHUNK - 1));
                    exp_beats[n_exp] = 1;
                    n_exp++;
                end else begin
                    exp_beats[n_exp-1]++;
                end
                a = a + 32'(bytes);
            end
        end else begin
            region = (len + 1) * bytes;
            base = a & ~(32'(region) - 32'd1);
            if (region <= CHUNK) begin
                exp_addr[0]  = a & ~32'(CHUNK - 1);
                exp_off[0]   = int'(a & 32'(CHUNK - 1));
                exp_beats[0] = len + 1;
                n_exp = 1;
            end else begin
                c = a & ~32'(CHUNK - 1);
                for (int k = 0; k < region / CHUNK; k++) begin
                    exp_addr[k]  = c;
                    exp_off[k]   = (k == 0) ? int'(a & 32'(CHUNK - 1)) : 0;
                    exp_beats[k] = CHUNK / bytes;
                    c = base + ((c - base + 32'(CHUNK)) % 32'(region));
                end
                n_exp = region / CHUNK;
            end
        end
    endtask

    task automatic run_txn(input string req, input logic [31:0] addr, input int len,
                           input int size, input logic [1:0] burst, input bit stall);
        logic [31:0] sn_addr;
        logic [6:0]  sn_beats;
        logic [5:0]  sn_off;
        logic        sn_last, sn_rmw, held;
        int got, cyc;
        bit done;
        build_exp(addr, len, size, burst);
        @(negedge clk);
        while (!(s_ready && rd_s_ready)) @(negedge clk);
        s_valid = 1'b1; s_addr = addr; s_len = 8'(len); s_size = 3'(size); s_burst = burst;
        @(negedge clk);
        s_valid = 1'b0;
        check_val("R1", "s_ready while splitting", longint'(s_ready), 0);
        check_val("R1", "m_valid after accept", longint'(m_valid), 1);
        got = 0; cyc = 0; done = 1'b0; held = 1'b0;
        sn_addr = '0; sn_beats = '0; sn_off = '0; sn_last = 1'b0; sn_rmw = 1'b0;
        while (!done && cyc < 1000) begin
            m_ready = stall ? (cyc % 3 == 2) : 1'b1;
            if (held) begin
                check_val("R2", "valid held", longint'(m_valid), 1);
                check_val("R2", "addr held", longint'(m_addr), longint'(sn_addr));
                check_val("R2", "beats held", longint'(m_beats), longint'(sn_beats));
                check_val("R2", "offset held", longint'(m_offset), longint'(sn_off));
                check_val("R2", "last/rmw held", longint'({m_last, m_rmw}), longint'({sn_last, sn_rmw}));
            end
            held = 1'b0;
            if (m_valid) begin
                if (m_ready) begin
                    if (got < n_exp) begin
                        check_val(req, "chunk address", longint'(m_addr), longint'(exp_addr[got]));
                        check_val(req, "chunk beats", longint'(m_beats), longint'(exp_beats[got]));
                        check_val(req, "chunk offset", longint'(m_offset), longint'(exp_off[got]));
                        check_val("R7", "last flag", longint'(m_last), (got == n_exp - 1) ? 1 : 0);
                        check_val("R8", "rmw tag", longint'(m_rmw),
                                  ((exp_beats[got] << size) != CHUNK) ? 1 : 0);
                        check_val("R3", "chunk alignment", longint'(m_addr % CHUNK), 0);
                    end
                    got++;
                    if (m_last) done = 1'b1;
                end else begin
                    held = 1'b1;
                    sn_addr = m_addr; sn_beats = m_beats; sn_off = m_offset;
                    sn_last = m_last; sn_rmw = m_rmw;
                end
            end
            @(negedge clk);
            cyc++;
        end
        m_ready = 1'b0;
        check_val(req, "command count", got, n_exp);
        check_val("R7", "s_ready after last", longint'(s_ready), 1);
        check_val("R7", "m_valid after last", longint'(m_valid), 0);
    endtask

    task automatic test_reset();
        check_val("R10", "s_ready after reset", longint'(s_ready), 1);
        check_val("R10", "m_valid after reset", longint'(m_valid), 0);
    endtask

    task automatic test_incr_aligned();
        rd_cnt = 0; rd_rmw = 0; rd_misalign = 0;
        run_txn("R4", 32'h0000_1000, 15, 3, 2'b01, 1'b0);
        repeat (6) @(negedge clk);
        check_val("R3", "BL4 instance chunk count", rd_cnt, 4);
        check_val("R3", "BL4 instance misaligned", rd_misalign, 0);
        check_val("R8", "read instance rmw count", rd_rmw, 0);
    endtask

    task automatic test_incr_unaligned_stall();
        run_txn("R4", 32'h0000_2030, 11, 3, 2'b01, 1'b1);
    endtask

    task automatic test_incr_narrow();
        run_txn("R4", 32'h0000_3006, 3, 1, 2'b01, 1'b0);
    endtask

    task automatic test_wrap_small();
        run_txn("R5", 32'h0000_4018, 3, 3, 2'b10, 1'b0);
    endtask

    task automatic test_wrap_large();
        run_txn("R6", 32'h0000_5050, 15, 3, 2'b10, 1'b1);
    endtask

    task automatic test_code_zero_as_incr();
        run_txn("R9", 32'h0000_6038, 1, 3, 2'b00, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_incr_aligned();
        test_incr_unaligned_stall();
        test_incr_narrow();
        test_wrap_small();
        test_wrap_large();
        test_code_zero_as_incr();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule